// File: doc/BRIEF.md
# Message Object Interface Transfer Unit

This block copies data in either direction between a set of staging registers and one entry of a small message-object store, as found in a CAN-style controller. Software first fills in an 8-bit command mask. The mask gives the direction of the copy and picks which field groups take part: the mask group, the arbitration group, the control group, data bytes 0-3 and data bytes 4-7. Software then writes an object number into the request register. That write starts the copy, and a busy flag is shown for the one cycle the copy takes.

A copy from the store into the staging registers can clear the object's interrupt-pending flag, its new-data flag, or both. The staging registers show the flag values from just before the clear. A copy into the store can set the object's transmit-request flag. Any object number is folded onto a valid entry. Number 0 reaches the last object, and numbers above the object count wrap back to the first.

Top module: `msgobj_xfer`

## Requirements
- R1: After reset the command mask reads 0, busy is 0 and every staging register reads 0. The mask register (address 0) keeps only bits 7:0 of a write, and bits 31:8 always read as 0.
- R2: When mask bit 7 is 1, a transfer copies the selected field groups from the staging registers into the addressed object. When bit 7 is 0, it copies the selected groups from the object into the staging registers.
- R3: A write to the request register (address 1, number in bits 5:0) while idle makes busy (request readback bit 15 and the busy port) 1 for exactly one cycle, and the transfer takes effect at the end of that cycle.
- R4: Mask bit 6 selects the mask group (address 2, bits 30:0), bit 5 the arbitration group (address 3), bit 4 the control group (address 4, bits 6:0), bit 1 data bytes 0-3 (address 5) and bit 0 data bytes 4-7 (address 6).
- R5: A field group whose mask bit is 0 is left unchanged in the destination, in both directions.
- R6: On a read transfer with bit 3 set, the object's interrupt-pending flag (control bit 4) is cleared. The staging control register shows the value from before the clear.
- R7: On a read transfer with bit 2 set, the object's new-data flag (control bit 5) is cleared. Bit 3 and bit 2 each act only on their own flag, whether or not the control group is selected.
- R8: On a write transfer with bit 2 set, the object's transmit-request flag (control bit 6) is set to 1. This holds even when the control group is not selected.
- R9: Object number n addresses entry ((n-1) mod 32). So 0 and 32 name the same object, and 33 names the same object as 1.
- R10: While busy is 1, every register write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that the command mask and the request number hold still for the whole busy cycle, and that no write that could change them lands while busy. The design enforces this by ignoring writes while busy, and the checks on the flags and on the staging registers depend on it. The stimulus writes the mask before each request and waits for busy to drop before any further access. The one exception is a deliberate staging write made during busy to check that it is ignored, and it is paired with a write transfer so the staging register has no other source in that cycle.

// File: rtl/msgobj_pkg.sv
// Shared field widths, bit positions and register addresses for the
// message-object transfer unit. Assumes a 32-bit register bus.
package msgobj_pkg;
    localparam int REG_W  = 32;
    localparam int MASK_W = 31;
    localparam int ARB_W  = 32;
    localparam int CTL_W  = 7;

    // command mask bit positions
    localparam int CM_DIR  = 7;
    localparam int CM_MSK  = 6;
    localparam int CM_ARB  = 5;
    localparam int CM_CTL  = 4;
    localparam int CM_CLRI = 3;
    localparam int CM_NDTX = 2;
    localparam int CM_DA   = 1;
    localparam int CM_DB   = 0;

    // control group flag positions
    localparam int CTL_INTPND = 4;
    localparam int CTL_NEWDAT = 5;
    localparam int CTL_TXRQST = 6;

    localparam int BUSY_BIT = 15;

    typedef enum logic [2:0] {
        A_CMASK = 3'd0,
        A_REQ   = 3'd1,
        A_IMSK  = 3'd2,
        A_IARB  = 3'd3,
        A_ICTL  = 3'd4,
        A_IDA   = 3'd5,
        A_IDB   = 3'd6
    } addr_e;

    typedef struct packed {
        logic [MASK_W-1:0] msk;
        logic [ARB_W-1:0]  arb;
        logic [CTL_W-1:0]  ctl;
        logic [REG_W-1:0]  da;
        logic [REG_W-1:0]  db;
    } obj_t;
endpackage

// File: rtl/msgobj_cmd_regs.sv
// Command mask and request registers with the one-cycle busy sequencer.
// Assumes the write port is qualified by the caller only through wr_en;
// all writes are dropped while busy.
module msgobj_cmd_regs
    import msgobj_pkg::*;
#(
    parameter int MNUM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [7:0]        cmd_mask,
    output logic [MNUM_W-1:0] mnum,
    output logic              busy
);
    logic accept;
    assign accept = wr_en && !busy;

    // hold mask and object number, raise busy for one cycle per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_mask <= '0;
            mnum     <= '0;
            busy     <= 1'b0;
        end else begin
            busy <= accept && (wr_addr == A_REQ);
            if (accept && wr_addr == A_CMASK) cmd_mask <= wr_data[7:0];
            if (accept && wr_addr == A_REQ)   mnum     <= wr_data[MNUM_W-1:0];
        end
    end
endmodule

// File: rtl/msgobj_store.sv
// Message-object array. One entry is updated per transfer: field groups
// are written on a write transfer, flags are cleared on a read transfer.
// Assumes do_wr and do_rd are never high together.
module msgobj_store
    import msgobj_pkg::*;
#(
    parameter int NOBJ  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             do_wr,
    input  logic             do_rd,
    input  logic [7:0]       cm,
    input  obj_t             wdata,
    output obj_t             sel
);
    obj_t objs [NOBJ];
    obj_t nxt;

    assign sel = objs[idx];

    // next value of the addressed entry for either direction
    always_comb begin
        nxt = sel;
        if (do_wr) begin
            if (cm[CM_MSK]) nxt.msk = wdata.msk;
            if (cm[CM_ARB]) nxt.arb = wdata.arb;
            if (cm[CM_CTL]) nxt.ctl = wdata.ctl;
            if (cm[CM_DA])  nxt.da  = wdata.da;
            if (cm[CM_DB])  nxt.db  = wdata.db;
            if (cm[CM_NDTX]) nxt.ctl[CTL_TXRQST] = 1'b1;
        end else begin
            if (cm[CM_CLRI]) nxt.ctl[CTL_INTPND] = 1'b0;
            if (cm[CM_NDTX]) nxt.ctl[CTL_NEWDAT] = 1'b0;
        end
    end

    // entry storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NOBJ; i++) objs[i] <= '0;
        end else if (do_wr || do_rd) begin
            objs[idx] <= nxt;
        end
    end
endmodule

// File: rtl/msgobj_if_regs.sv
// Staging registers seen by software. Loaded by host writes when idle, or
// group by group from the store on a read transfer.
// Assumes host_we is already blocked while a transfer runs.
module msgobj_if_regs
    import msgobj_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             load,
    input  logic [7:0]       cm,
    input  obj_t             src,
    output obj_t             ifq
);
    // host writes and selective loads from the addressed object
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifq <= '0;
        end else if (load) begin
            if (cm[CM_MSK]) ifq.msk <= src.msk;
            if (cm[CM_ARB]) ifq.arb <= src.arb;
            if (cm[CM_CTL]) ifq.ctl <= src.ctl;
            if (cm[CM_DA])  ifq.da  <= src.da;
            if (cm[CM_DB])  ifq.db  <= src.db;
        end else if (host_we) begin
            case (wr_addr)
                A_IMSK:  ifq.msk <= wr_data[MASK_W-1:0];
                A_IARB:  ifq.arb <= wr_data[ARB_W-1:0];
                A_ICTL:  ifq.ctl <= wr_data[CTL_W-1:0];
                A_IDA:   ifq.da  <= wr_data;
                A_IDB:   ifq.db  <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msgobj_xfer.sv
// Top of the message-object transfer unit: command registers, staging
// registers, object store and the read-back multiplexer.
// Assumes NOBJ is a power of two so the number fold is a plain truncation.
module msgobj_xfer
    import msgobj_pkg::*;
#(
    parameter int NOBJ   = 32,
    parameter int MNUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             busy
);
    localparam int IDX_W = $clog2(NOBJ);

    logic [7:0]        cmd_mask;
    logic [MNUM_W-1:0] mnum;
    logic [MNUM_W-1:0] mnum_m1;
    logic [IDX_W-1:0]  idx;
    logic              do_wr, do_rd;
    obj_t              if_q;
    obj_t              sel_obj;

    msgobj_cmd_regs #(.MNUM_W(MNUM_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_mask(cmd_mask), .mnum(mnum), .busy(busy)
    );

    assign mnum_m1 = mnum - MNUM_W'(1);
    assign idx     = mnum_m1[IDX_W-1:0];
    assign do_wr   = busy &&  cmd_mask[CM_DIR];
    assign do_rd   = busy && !cmd_mask[CM_DIR];

    msgobj_store #(.NOBJ(NOBJ), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx), .do_wr(do_wr), .do_rd(do_rd),
        .cm(cmd_mask), .wdata(if_q), .sel(sel_obj)
    );

    msgobj_if_regs u_if (
        .clk(clk), .rst_n(rst_n), .host_we(wr_en && !busy), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(do_rd), .cm(cmd_mask), .src(sel_obj), .ifq(if_q)
    );

    // register read-back multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMASK: rd_data[7:0] = cmd_mask;
            A_REQ: begin
                rd_data[MNUM_W-1:0] = mnum;
                rd_data[BUSY_BIT]   = busy;
            end
            A_IMSK:  rd_data[MASK_W-1:0] = if_q.msk;
            A_IARB:  rd_data = if_q.arb;
            A_ICTL:  rd_data[CTL_W-1:0] = if_q.ctl;
            A_IDA:   rd_data = if_q.da;
            A_IDB:   rd_data = if_q.db;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/msgobj_xfer_chk.sv
// Assertion checker for msgobj_xfer, attached through bind below.
// Assumes mask and object number stay put while busy (writes are dropped).
module msgobj_xfer_chk
    import msgobj_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [2:0]       rd_addr,
    input logic [REG_W-1:0] rd_data,
    input logic             busy,
    input logic [7:0]       cmd_mask,
    input logic [REG_W-1:0] if_da,
    input logic [CTL_W-1:0] sel_ctl
);
    // R1
    mask_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CMASK) |-> (rd_data[31:8] == '0));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr == A_REQ) |=> busy);

    // R3
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R10
    if_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == A_IDA && cmd_mask[CM_DIR]) |=> $stable(if_da));

    // R6
    intpnd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_mask[CM_DIR] && cmd_mask[CM_CLRI]) |=> !sel_ctl[CTL_INTPND]);

    // R8
    txrqst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_mask[CM_DIR] && cmd_mask[CM_NDTX]) |=> sel_ctl[CTL_TXRQST]);
endmodule

bind msgobj_xfer msgobj_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cmd_mask(cmd_mask),
    .if_da(if_q.da), .sel_ctl(sel_obj.ctl)
);

// File: tb/tb_msgobj_xfer.sv
module tb_msgobj_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    msgobj_xfer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic xfer(input logic [7:0] m, input logic [31:0] n);
        wr(3'd0, {24'd0, m});
        wr(3'd1, n);
        while (busy) @(negedge clk);
    endtask

    task automatic set_if(input logic [31:0] mk, input logic [31:0] ar,
                          input logic [31:0] ct, input logic [31:0] a, input logic [31:0] b);
        wr(3'd2, mk); wr(3'd3, ar); wr(3'd4, ct); wr(3'd5, a); wr(3'd6, b);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 mask reset", v, 32'h0);
        rd(3'd1, v); check("R1 busy reset", v, 32'h0);
        rd(3'd5, v); check("R1 data A reset", v, 32'h0);
        rd(3'd4, v); check("R1 ctl reset", v, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R1 upper mask bits", v, 32'h0000_00FF);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_full_round_trip();
        logic [31:0] v;
        set_if(32'h7ABC_1234, 32'hDEAD_BEEF, 32'h0000_0005, 32'h1111_2222, 32'h3333_4444);
        xfer(8'hF3, 32'd5);
        set_if(0, 0, 0, 0, 0);
        xfer(8'h73, 32'd5);
        rd(3'd2, v); check("R2 R4 mask group", v, 32'h7ABC_1234);
        rd(3'd3, v); check("R2 R4 arb group", v, 32'hDEAD_BEEF);
        rd(3'd4, v); check("R2 R4 ctl group", v, 32'h0000_0005);
        rd(3'd5, v); check("R2 R4 data A", v, 32'h1111_2222);
        rd(3'd6, v); check("R2 R4 data B", v, 32'h3333_4444);
    endtask

    task automatic t_partial();
        logic [31:0] v;
        set_if(32'h0000_00AA, 32'hBBBB_BBBB, 32'h0000_0003, 32'hCCCC_CCCC, 32'hDDDD_DDDD);
        xfer(8'h02, 32'd5);
        rd(3'd5, v); check("R5 read A loaded", v, 32'h1111_2222);
        rd(3'd6, v); check("R5 read B untouched", v, 32'hDDDD_DDDD);
        rd(3'd3, v); check("R5 read arb untouched", v, 32'hBBBB_BBBB);
        rd(3'd2, v); check("R5 read mask untouched", v, 32'h0000_00AA);
        wr(3'd6, 32'h5555_6666);
        wr(3'd5, 32'h9999_9999);
        xfer(8'h81, 32'd5);
        set_if(0, 0, 0, 0, 0);
        xfer(8'h73, 32'd5);
        rd(3'd5, v); check("R5 write A untouched", v, 32'h1111_2222);
        rd(3'd6, v); check("R5 write B written", v, 32'h5555_6666);
        rd(3'd3, v); check("R5 write arb untouched", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        wr(3'd4, 32'h0000_0038);
        xfer(8'h90, 32'd7);
        wr(3'd4, 32'h0);
        xfer(8'h1C, 32'd7);
        rd(3'd4, v); check("R6 R7 pre-clear flags shown", v, 32'h0000_0038);
        xfer(8'h10, 32'd7);
        rd(3'd4, v); check("R6 R7 flags cleared", v, 32'h0000_0008);
        wr(3'd4, 32'h0000_0030);
        xfer(8'h90, 32'd7);
        xfer(8'h08, 32'd7);
        xfer(8'h10, 32'd7);
        rd(3'd4, v); check("R7 only pending cleared", v, 32'h0000_0020);
    endtask

    task automatic t_txrqst();
        logic [31:0] v;
        xfer(8'h84, 32'd9);
        wr(3'd4, 32'h0);
        xfer(8'h10, 32'd9);
        rd(3'd4, v); check("R8 txrqst set", v, 32'h0000_0040);
    endtask

    task automatic t_number_fold();
        logic [31:0] v;
        wr(3'd5, 32'hA0A0_0032);
        xfer(8'h82, 32'd32);
        wr(3'd5, 32'h0);
        xfer(8'h02, 32'd0);
        rd(3'd5, v); check("R9 number 0 is 32", v, 32'hA0A0_0032);
        wr(3'd5, 32'hB0B0_0001);
        xfer(8'h82, 32'd1);
        wr(3'd5, 32'h0);
        xfer(8'h02, 32'd33);
        rd(3'd5, v); check("R9 number 33 is 1", v, 32'hB0B0_0001);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(3'd5, 32'h1234_5678);
        wr(3'd0, 32'h82);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd12;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'hFFFF_0000;
        rd_addr = 3'd1;
        #1 check("R3 busy set", {31'd0, busy}, 32'd1);
        check("R3 busy readback", rd_data, 32'h0000_800C);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R3 busy one cycle", {31'd0, busy}, 32'd0);
        rd(3'd5, v); check("R10 write while busy ignored", v, 32'h1234_5678);
        wr(3'd5, 32'h0);
        xfer(8'h02, 32'd12);
        rd(3'd5, v); check("R3 transfer took effect", v, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_round_trip();
        t_partial();
        t_flags();
        t_txrqst();
        t_number_fold();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule